// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller for a small out-of-order floating-point execution cluster. It owns a status entry per functional unit and a producer table for every architectural register. Each cycle it is offered at most one decoded instruction, made of an operation class, a destination register and two source registers. It decides whether that instruction may enter a unit now. For every occupied unit it decides when the unit may fetch its operands. For every finished unit it decides when the unit may commit its result.

The cluster has one integer/load unit, `N_MUL` multipliers (two by default), one adder and one divider. Unit indices are fixed: index 0 is integer/load, indices 1..N_MUL are the multipliers, then the adder, then the divider. With the defaults this gives the grant-vector bits [0]=int, [1]=mul0, [2]=mul1, [3]=add, [4]=div. A register whose entry holds tag 0 has no pending producer. Unit `i` is tagged `i+1`.

The functional units are external handshake endpoints. A unit fetches its operands in the cycle its read grant is high. It pulses its done strobe when its result is ready, and it drives the result in the cycle its write grant is high. All grant outputs are combinational from the current state and the presented instruction.

Top module: `sb_hazard_ctl`

## Requirements
- R1: After reset, asynchronous or at start-up, every unit is idle and no register has a producer. `rd_grant` and `wr_grant` are zero, and `in_ready` is high for any class and destination.
- R2: An instruction is held (`in_ready` low) when every unit of its class (`in_op`: 0 int/load, 1 multiply, 2 add, 3 divide) is occupied. A multiply goes to the lowest-index free multiplier.
- R3: An instruction is held while its destination register already has a producer in flight. Later instructions wait behind it in order.
- R4: A unit whose two sources had no pending producer at issue gets a one-cycle `rd_grant` in the cycle after issue.
- R5: A unit whose source had a pending producer gets no `rd_grant` until that producer's write. The grant comes in the cycle after the producer's `wr_grant`, if the other source is also ready.
- R6: A `fu_done` pulse from a unit that has read its operands makes it request write-back. Absent WAR blocking and higher-priority requests, its `wr_grant` is high in the next cycle.
- R7: A unit's write-back is held while another occupied unit has the same register as a ready, still unread source. It proceeds in the cycle after that read.
- R8: When several units may write back in one cycle, only the lowest-index one gets `wr_grant`.
- R9: When an instruction is issued in the same cycle as the write-back of its source's producer, that source counts as ready.
- R10: A written-back unit and its destination register can be claimed again from the next cycle. In the write-back cycle itself they still count as occupied.
- R11: A `fu_done` pulse from a unit that is idle or still waiting for operands is ignored.
- R12: `iss_grant` is one-hot on the chosen unit only when `in_valid` and `in_ready` are both high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| in_valid | input | 1 | A decoded instruction is presented |
| in_op | input | 2 | Operation class: 0 int/load, 1 multiply, 2 add, 3 divide |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_ready | output | 1 | The presented instruction may issue this cycle |
| iss_grant | output | N_MUL+3 | One-hot unit receiving the instruction |
| rd_grant | output | N_MUL+3 | Units allowed to read operands this cycle |
| fu_done | input | N_MUL+3 | Per-unit completion strobes |
| wr_grant | output | N_MUL+3 | Unit allowed to write its result this cycle |

## Verification
The bench drives a dependent chain through the multipliers and adder and checks that a consumer is not granted a read before its producer commits. Reading early would surface as a premature `rd_grant`. It sets up a register that an older multiply still has to read while a newer multiply wants to overwrite it. A design that checked WAR wrongly would commit the overwrite while the reader is blocked, or would never release the writer. Same-cycle cases are aimed at directly. An issue that coincides with the write-back of its source would hang forever without the forwarding. Two completions in one cycle would grant both or the wrong unit if the priority were off. A stray done strobe to an idle unit would produce a phantom write-back. A mid-run reset must wipe the register producer table, or a later issue would stall on stale state.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } fu_stage_e;

  localparam logic [1:0] CLS_INT = 2'd0;
  localparam logic [1:0] CLS_MUL = 2'd1;
  localparam logic [1:0] CLS_ADD = 2'd2;
  localparam logic [1:0] CLS_DIV = 2'd3;

  // Unit ordering: int, N multipliers, add, div
  function automatic logic [1:0] unit_class(input int idx, input int n_mul);
    if (idx == 0)              return CLS_INT;
    else if (idx <= n_mul)     return CLS_MUL;
    else if (idx == n_mul + 1) return CLS_ADD;
    else                       return CLS_DIV;
  endfunction

endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_en,
  input  logic [REG_W-1:0] iss_dst,
  input  logic [REG_W-1:0] iss_src1,
  input  logic [REG_W-1:0] iss_src2,
  input  logic [TAG_W-1:0] iss_q1,
  input  logic [TAG_W-1:0] iss_q2,
  input  logic             rd_en,
  input  logic             done_in,
  input  logic             wr_en,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  output fu_stage_e        stage_o,
  output logic [REG_W-1:0] fi_o,
  output logic [REG_W-1:0] fj_o,
  output logic [REG_W-1:0] fk_o,
  output logic             rj_o,
  output logic             rk_o,
  output logic             rd_req_o
);

  fu_stage_e        stage_q, stage_d;
  logic [REG_W-1:0] fi_q, fi_d, fj_q, fj_d, fk_q, fk_d;
  logic [TAG_W-1:0] qj_q, qj_d, qk_q, qk_d;
  logic             rj_q, rj_d, rk_q, rk_d;

  always_comb begin
    stage_d = stage_q;
    fi_d    = fi_q;
    fj_d    = fj_q;
    fk_d    = fk_q;
    qj_d    = qj_q;
    qk_d    = qk_q;
    rj_d    = rj_q;
    rk_d    = rk_q;
    unique case (stage_q)
      ST_FREE: begin
        if (iss_en) begin
          stage_d = ST_WAIT;
          fi_d    = iss_dst;
          fj_d    = iss_src1;
          fk_d    = iss_src2;
          qj_d    = iss_q1;
          qk_d    = iss_q2;
          rj_d    = (iss_q1 == '0);
          rk_d    = (iss_q2 == '0);
        end
      end
      ST_WAIT: begin
        if (rd_en) begin
          stage_d = ST_EXEC;
          rj_d    = 1'b0;
          rk_d    = 1'b0;
        end else begin
          if (bc_valid && (qj_q != '0) && (qj_q == bc_tag)) begin
            qj_d = '0;
            rj_d = 1'b1;
          end
          if (bc_valid && (qk_q != '0) && (qk_q == bc_tag)) begin
            qk_d = '0;
            rk_d = 1'b1;
          end
        end
      end
      ST_EXEC: begin
        if (done_in) stage_d = ST_DONE;
      end
      ST_DONE: begin
        if (wr_en) stage_d = ST_FREE;
      end
      default: stage_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_FREE;
      fi_q    <= '0;
      fj_q    <= '0;
      fk_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      fi_q    <= fi_d;
      fj_q    <= fj_d;
      fk_q    <= fk_d;
      qj_q    <= qj_d;
      qk_q    <= qk_d;
      rj_q    <= rj_d;
      rk_q    <= rk_d;
    end
  end

  assign stage_o  = stage_q;
  assign fi_o     = fi_q;
  assign fj_o     = fj_q;
  assign fk_o     = fk_q;
  assign rj_o     = rj_q;
  assign rk_o     = rk_q;
  assign rd_req_o = (stage_q == ST_WAIT) && rj_q && rk_q;

  // R12: the issue logic only targets an idle entry
  a_r12_issue_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en |-> (stage_q == ST_FREE));

  // R5: an operand read never happens while a producer tag is outstanding
  a_r5_read_tags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (qj_q == '0 && qk_q == '0));

  // R6: write-back is only granted after completion was reported
  a_r6_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (stage_q == ST_DONE));

  // R11: a done strobe before the operand read cannot mark completion
  a_r11_early_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (done_in && (stage_q == ST_FREE || stage_q == ST_WAIT)) |=> (stage_q != ST_DONE));

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
#(
  parameter int N_MUL  = 2,
  parameter int NUM_FU = N_MUL + 3,
  parameter int TAG_W  = 3
) (
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic              dst_pending,
  input  logic [NUM_FU-1:0] unit_free,
  output logic              in_ready,
  output logic [NUM_FU-1:0] iss_grant,
  output logic [TAG_W-1:0]  iss_tag
);

  logic [NUM_FU-1:0] class_hit;
  logic [NUM_FU-1:0] pick;

  for (genvar i = 0; i < NUM_FU; i++) begin : g_cls
    localparam logic [1:0] UCLS = unit_class(i, N_MUL);
    assign class_hit[i] = unit_free[i] && (in_op == UCLS);
  end

  // lowest index wins among free units of the requested class
  always_comb begin
    pick    = '0;
    iss_tag = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (class_hit[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        iss_tag = TAG_W'(i + 1);
      end
    end
  end

  assign in_ready  = (|class_hit) && !dst_pending;
  assign iss_grant = (in_valid && in_ready) ? pick : '0;

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int NUM_FU = 5,
  parameter int REG_W  = 5,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] wr_req,
  input  logic [NUM_FU-1:0] waiting,
  input  logic [REG_W-1:0]  fi [NUM_FU],
  input  logic [REG_W-1:0]  fj [NUM_FU],
  input  logic [REG_W-1:0]  fk [NUM_FU],
  input  logic [NUM_FU-1:0] rj,
  input  logic [NUM_FU-1:0] rk,
  output logic [NUM_FU-1:0] wr_grant,
  output logic              wr_valid,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [REG_W-1:0]  wr_dst
);

  logic [NUM_FU-1:0] war_blk;
  logic [NUM_FU-1:0] elig;

  // WAR: another unit still has to read the old contents of our target
  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      war_blk[f] = 1'b0;
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != f && waiting[g] &&
            ((rj[g] && fj[g] == fi[f]) || (rk[g] && fk[g] == fi[f])))
          war_blk[f] = 1'b1;
      end
    end
  end

  assign elig = wr_req & ~war_blk;

  always_comb begin
    wr_grant = '0;
    wr_tag   = '0;
    wr_dst   = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (elig[i]) begin
        wr_grant    = '0;
        wr_grant[i] = 1'b1;
        wr_tag      = TAG_W'(i + 1);
        wr_dst      = fi[i];
      end
    end
  end

  assign wr_valid = |elig;

  // R8: at most one result bus owner per cycle
  a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant));

  // R6: a granted writer must have been requesting
  a_r6_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant & ~wr_req) == '0);

endmodule

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl
  import sb_pkg::*;
#(
  parameter int N_MUL    = 2,
  parameter int NUM_REGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_op,
  input  logic [$clog2(NUM_REGS)-1:0] in_dst,
  input  logic [$clog2(NUM_REGS)-1:0] in_src1,
  input  logic [$clog2(NUM_REGS)-1:0] in_src2,
  output logic                 in_ready,
  output logic [N_MUL+2:0]     iss_grant,
  output logic [N_MUL+2:0]     rd_grant,
  input  logic [N_MUL+2:0]     fu_done,
  output logic [N_MUL+2:0]     wr_grant
);

  localparam int NUM_FU = N_MUL + 3;
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int TAG_W  = $clog2(NUM_FU + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // register result status: producer tag per register, 0 = none
  logic [TAG_W-1:0] regstat_q [NUM_REGS];
  logic [TAG_W-1:0] regstat_d [NUM_REGS];

  fu_stage_e         stage_w [NUM_FU];
  logic [REG_W-1:0]  fi_w [NUM_FU];
  logic [REG_W-1:0]  fj_w [NUM_FU];
  logic [REG_W-1:0]  fk_w [NUM_FU];
  logic [NUM_FU-1:0] rj_w, rk_w, rd_req_w;
  logic [NUM_FU-1:0] unit_free, waiting, wr_req;

  logic              wr_valid;
  logic [TAG_W-1:0]  wr_tag;
  logic [REG_W-1:0]  wr_dst;
  logic [TAG_W-1:0]  iss_tag;
  logic [TAG_W-1:0]  q1_raw, q2_raw, q1_eff, q2_eff;
  logic              iss_fire;

  for (genvar i = 0; i < NUM_FU; i++) begin : g_stat
    assign unit_free[i] = (stage_w[i] == ST_FREE);
    assign waiting[i]   = (stage_w[i] == ST_WAIT);
    assign wr_req[i]    = (stage_w[i] == ST_DONE);
  end

  sb_issue_ctl #(
    .N_MUL  (N_MUL),
    .NUM_FU (NUM_FU),
    .TAG_W  (TAG_W)
  ) u_issue (
    .in_valid    (in_valid),
    .in_op       (in_op),
    .dst_pending (regstat_q[in_dst] != '0),
    .unit_free   (unit_free),
    .in_ready    (in_ready),
    .iss_grant   (iss_grant),
    .iss_tag     (iss_tag)
  );

  assign iss_fire = |iss_grant;

  // a source whose producer commits this very cycle is taken as ready
  assign q1_raw = regstat_q[in_src1];
  assign q2_raw = regstat_q[in_src2];
  assign q1_eff = (wr_valid && q1_raw == wr_tag) ? '0 : q1_raw;
  assign q2_eff = (wr_valid && q2_raw == wr_tag) ? '0 : q2_raw;

  sb_wb_arbiter #(
    .NUM_FU (NUM_FU),
    .REG_W  (REG_W),
    .TAG_W  (TAG_W)
  ) u_wb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_req   (wr_req),
    .waiting  (waiting),
    .fi       (fi_w),
    .fj       (fj_w),
    .fk       (fk_w),
    .rj       (rj_w),
    .rk       (rk_w),
    .wr_grant (wr_grant),
    .wr_valid (wr_valid),
    .wr_tag   (wr_tag),
    .wr_dst   (wr_dst)
  );

  for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
    sb_fu_entry #(
      .REG_W (REG_W),
      .TAG_W (TAG_W)
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .iss_en   (iss_grant[i]),
      .iss_dst  (in_dst),
      .iss_src1 (in_src1),
      .iss_src2 (in_src2),
      .iss_q1   (q1_eff),
      .iss_q2   (q2_eff),
      .rd_en    (rd_req_w[i]),
      .done_in  (fu_done[i]),
      .wr_en    (wr_grant[i]),
      .bc_valid (wr_valid),
      .bc_tag   (wr_tag),
      .stage_o  (stage_w[i]),
      .fi_o     (fi_w[i]),
      .fj_o     (fj_w[i]),
      .fk_o     (fk_w[i]),
      .rj_o     (rj_w[i]),
      .rk_o     (rk_w[i]),
      .rd_req_o (rd_req_w[i])
    );
  end

  assign rd_grant = rd_req_w;

  always_comb begin
    regstat_d = regstat_q;
    if (wr_valid) regstat_d[wr_dst] = '0;
    if (iss_fire) regstat_d[in_dst] = iss_tag;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int r = 0; r < NUM_REGS; r++) regstat_q[r] <= '0;
    end else begin
      regstat_q <= regstat_d;
    end
  end

  // R3: an accepted destination is claimed in the following cycle
  a_r3_dst_claimed: assert property (@(posedge clk) disable iff (!rst_int_n)
    iss_fire |=> (regstat_q[$past(in_dst)] != '0));

  // R10: a unit committing this cycle is not handed a new instruction yet
  a_r10_no_reuse_same_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_grant & iss_grant) == '0);

  // R12: issue only goes out for a presented instruction
  a_r12_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    iss_fire |-> in_valid);

endmodule

// File: tb/sb_hazard_ctl_test.sv
module sb_hazard_ctl_test;

  localparam int NF = 5;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_op;
  logic [4:0]    in_dst, in_src1, in_src2;
  logic          in_ready;
  logic [NF-1:0] iss_grant, rd_grant, wr_grant, fu_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  sb_hazard_ctl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_dst    (in_dst),
    .in_src1   (in_src1),
    .in_src2   (in_src2),
    .in_ready  (in_ready),
    .iss_grant (iss_grant),
    .rd_grant  (rd_grant),
    .fu_done   (fu_done),
    .wr_grant  (wr_grant)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // one row per cycle: stimulus then expected combinational outputs
  typedef struct packed {
    logic [3:0] req;
    logic       v;
    logic [1:0] op;
    logic [4:0] dst;
    logic [4:0] s1;
    logic [4:0] s2;
    logic [4:0] done;
    logic       rdy;
    logic [4:0] iss;
    logic [4:0] rd;
    logic [4:0] wr;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd12, 1'b1, 2'd0, 5'd2,  5'd0,  5'd0,  5'b00000, 1'b1, 5'b00001, 5'b00000, 5'b00000}, // R12 int issue
    '{4'd4,  1'b1, 2'd1, 5'd4,  5'd2,  5'd6,  5'b00000, 1'b1, 5'b00010, 5'b00001, 5'b00000}, // R4 int reads
    '{4'd6,  1'b1, 2'd2, 5'd8,  5'd4,  5'd2,  5'b00001, 1'b1, 5'b01000, 5'b00000, 5'b00000}, // R6 int done
    '{4'd6,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 1'b0, 5'b00000, 5'b00000, 5'b00001}, // R6 int writes
    '{4'd5,  1'b1, 2'd1, 5'd12, 5'd0,  5'd0,  5'b00000, 1'b1, 5'b00100, 5'b00010, 5'b00000}, // R5 mul0 after producer
    '{4'd2,  1'b1, 2'd1, 5'd14, 5'd0,  5'd0,  5'b00000, 1'b0, 5'b00000, 5'b00100, 5'b00000}, // R2 multipliers full
    '{4'd2,  1'b1, 2'd1, 5'd14, 5'd0,  5'd0,  5'b00010, 1'b0, 5'b00000, 5'b00000, 5'b00000}, // R2 still full
    '{4'd5,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00100, 1'b1, 5'b00000, 5'b00000, 5'b00010}, // R5 mul0 writes
    '{4'd9,  1'b1, 2'd3, 5'd16, 5'd12, 5'd0,  5'b00000, 1'b1, 5'b10000, 5'b01000, 5'b00100}, // R9 issue during write
    '{4'd9,  1'b1, 2'd0, 5'd20, 5'd0,  5'd0,  5'b00000, 1'b1, 5'b00001, 5'b10000, 5'b00000}, // R9 div reads
    '{4'd2,  1'b1, 2'd1, 5'd22, 5'd24, 5'd20, 5'b00000, 1'b1, 5'b00010, 5'b00001, 5'b00000}, // R2 lowest mul
    '{4'd2,  1'b1, 2'd1, 5'd24, 5'd0,  5'd0,  5'b00000, 1'b1, 5'b00100, 5'b00000, 5'b00000}, // R2 next mul
    '{4'd4,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 1'b0, 5'b00000, 5'b00100, 5'b00000}, // R4 mul1 reads
    '{4'd6,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00100, 1'b0, 5'b00000, 5'b00000, 5'b00000}, // R6 mul1 done
    '{4'd7,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b11000, 1'b0, 5'b00000, 5'b00000, 5'b00000}, // R7 mul1 blocked
    '{4'd8,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00001, 1'b0, 5'b00000, 5'b00000, 5'b01000}, // R8 add over div
    '{4'd8,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 1'b0, 5'b00000, 5'b00000, 5'b00001}, // R8 int over div
    '{4'd7,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 1'b1, 5'b00000, 5'b00010, 5'b10000}, // R7 still blocked
    '{4'd7,  1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b10000, 1'b1, 5'b00000, 5'b00000, 5'b00100}, // R7 released
    '{4'd10, 1'b1, 2'd2, 5'd8,  5'd0,  5'd0,  5'b00000, 1'b1, 5'b01000, 5'b00000, 5'b00000}, // R10 add reused
    '{4'd3,  1'b1, 2'd3, 5'd22, 5'd0,  5'd0,  5'b00000, 1'b0, 5'b00000, 5'b01000, 5'b00000}, // R3 WAW hold
    '{4'd3,  1'b1, 2'd3, 5'd22, 5'd0,  5'd0,  5'b00010, 1'b0, 5'b00000, 5'b00000, 5'b00000}, // R3 still held
    '{4'd10, 1'b1, 2'd3, 5'd22, 5'd0,  5'd0,  5'b00000, 1'b0, 5'b00000, 5'b00000, 5'b00010}, // R10 held in write cycle
    '{4'd10, 1'b1, 2'd3, 5'd22, 5'd0,  5'd0,  5'b10000, 1'b1, 5'b10000, 5'b00000, 5'b00000}, // R10 free next cycle
    '{4'd11, 1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 1'b1, 5'b00000, 5'b10000, 5'b00000}, // R11 div reads
    '{4'd11, 1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 1'b1, 5'b00000, 5'b00000, 5'b00000}  // R11 no phantom write
  };

  task automatic chk(input string tag, input string what, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b, input logic [4:0] dn);
    in_valid = v;
    in_op    = op;
    in_dst   = d;
    in_src1  = a;
    in_src2  = b;
    fu_done  = dn;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    repeat (3) @(negedge clk);
    #2;
    // R1: state while held in reset
    chk("R1", "in_ready", {4'd0, in_ready}, 5'd1);
    chk("R1", "rd_grant", rd_grant, 5'd0);
    chk("R1", "wr_grant", wr_grant, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "in_ready after release", {4'd0, in_ready}, 5'd1);
    chk("R1", "wr_grant after release", wr_grant, 5'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k].v, VEC[k].op, VEC[k].dst, VEC[k].s1, VEC[k].s2, VEC[k].done);
      #2;
      chk($sformatf("R%0d row %0d", VEC[k].req, k), "in_ready", {4'd0, in_ready}, {4'd0, VEC[k].rdy});
      chk($sformatf("R%0d row %0d", VEC[k].req, k), "iss_grant", iss_grant, VEC[k].iss);
      chk($sformatf("R%0d row %0d", VEC[k].req, k), "rd_grant", rd_grant, VEC[k].rd);
      chk($sformatf("R%0d row %0d", VEC[k].req, k), "wr_grant", wr_grant, VEC[k].wr);
    end

    // R1: asynchronous reset in mid-run wipes units and producer table
    @(negedge clk);
    drive(1'b0, 2'd3, 5'd22, 5'd0, 5'd0, 5'd0);
    #2;
    chk("R1", "div busy before reset", {4'd0, in_ready}, 5'd0);
    #3;
    rst_n = 1'b0;
    #2;
    chk("R1", "in_ready in reset", {4'd0, in_ready}, 5'd1);
    chk("R1", "rd_grant in reset", rd_grant, 5'd0);
    chk("R1", "wr_grant in reset", wr_grant, 5'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: done strobes to idle units produce nothing
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b11111);
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    #2;
    chk("R11", "wr_grant after stray done", wr_grant, 5'd0);
    chk("R11", "rd_grant after stray done", rd_grant, 5'd0);

    // R12: no issue without in_valid even when ready
    drive(1'b0, 2'd2, 5'd8, 5'd0, 5'd0, 5'd0);
    #2;
    chk("R12", "in_ready idle add", {4'd0, in_ready}, 5'd1);
    chk("R12", "iss_grant without valid", iss_grant, 5'd0);

    // R2: multiplies fill from the lowest index
    @(negedge clk);
    drive(1'b1, 2'd1, 5'd4, 5'd0, 5'd0, 5'd0);
    #2;
    chk("R2", "first multiply unit", iss_grant, 5'b00010);
    @(negedge clk);
    drive(1'b1, 2'd1, 5'd6, 5'd0, 5'd0, 5'd0);
    #2;
    chk("R2", "second multiply unit", iss_grant, 5'b00100);
    chk("R4", "mul0 read next cycle", rd_grant, 5'b00010);
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    #2;
    chk("R4", "mul1 read next cycle", rd_grant, 5'b00100);

    @(negedge clk);
    finish_run();
  end

endmodule